// File: doc/BRIEF.md
# ASID-Tagged Address Translation Unit with Table Walker

This block turns a 16-bit virtual address into a 16-bit physical address for one requester. Pages are 256 bytes: the upper byte of the address is the virtual page number and the lower byte is the page offset, which passes through unchanged. Recent translations sit in an eight-entry fully associative buffer. Each entry is tagged with an address-space identifier, so translations that belong to different processes can stay resident together.

A request is accepted only while the unit is idle. The unit first searches the buffer. On a miss it reads one 16-bit page-table entry from a linear table in memory through a single read port. It then either ends the request with a fault or installs the mapping and repeats the search. Fault handling, bringing pages into memory and eviction decisions in software are left to the surrounding system.

The controller has five states. IDLE accepts a request and goes to LOOKUP. LOOKUP returns to IDLE on a hit with the done strobe, or goes to WALK_REQ on a miss. WALK_REQ issues the memory read and goes to WALK_WAIT. WALK_WAIT holds until read data arrives. From there it returns to IDLE with a fault strobe, or moves to REFILL when the entry is usable. REFILL writes the buffer and goes back to LOOKUP for the retry.

Top module: `asid_tlb_xlate`

## Requirements
- R1: After reset the unit is idle: busy, done, fault_seg, fault_page and mem_req are all low.
- R2: A hit asserts done for one cycle. done is high in the second cycle after the accepting clock edge, and paddr equals the cached frame number in bits 15:8 with req_vaddr[7:0] in bits 7:0.
- R3: A hit requires a set valid bit, an equal page number (req_vaddr[15:8]) and an identifier equal to the cur_asid sampled at acceptance. The same page under a different identifier misses and walks the table.
- R4: On a miss the unit pulses mem_req for exactly one cycle with mem_addr = pt_base + 2 × page number. It accepts mem_rvalid any number of cycles (one or more) later.
- R5: Entry layout: bit 15 valid, bit 14 present, bits 13:12 protection, bits 7:0 frame number, bits 11:8 reserved. An entry with a reserved bit set is treated as invalid.
- R6: A fetched entry that is invalid ends the request with a one-cycle fault_seg and leaves the buffer unchanged.
- R7: A fetched entry that is valid but not present ends the request with a one-cycle fault_page and leaves the buffer unchanged.
- R8: A valid, present entry is installed under the request's identifier and the lookup is repeated. The repeat hits and gives done, paddr and prot, the last taken from entry bits 13:12. A later request for that page and identifier does not walk.
- R9: A refill takes the lowest-numbered free slot. When no slot is free it replaces slots in round-robin order, beginning with slot 0 after reset and advancing only on such replacements.
- R10: A one-cycle flush invalidates every slot, so each later request misses once.
- R11: busy is high from the cycle after acceptance until the cycle that carries the ending strobe. req_valid is ignored while busy.
- R12: Each request ends with exactly one of done, fault_seg or fault_page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all buffer slots |
| cur_asid | input | 8 | Identifier of the running process |
| pt_base | input | 16 | Byte address of the linear page table |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual address to translate |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Translation finished successfully |
| paddr | output | 16 | Physical address, valid with done |
| prot | output | 2 | Protection bits, valid with done |
| fault_seg | output | 1 | Request ended: invalid mapping |
| fault_page | output | 1 | Request ended: page not present |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 16 | Page-table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Page-table entry read |

## Verification
A slot that holds the wrong tag or frame shows up at the ports in the cycle of the next request for that page. It appears either as a walk that should not happen (a mem_req pulse on a page expected to hit) or as a wrong paddr together with done. A wrong replacement pointer or a fault that wrote the buffer stays hidden until the buffer is full. It then appears as an extra walk on the first page that should still be resident. For that reason the bench fills all eight slots and revisits each one after every eviction and fault. A stuck state machine stops the strobes, and the bench reports it within a few hundred cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT,
        ST_REFILL
    } xl_state_t;

    // Page-table entry layout (16-bit entry)
    localparam int PTE_W       = 16;
    localparam int PTE_V_BIT   = 15;
    localparam int PTE_P_BIT   = 14;
    localparam int PTE_PR_HI   = 13;
    localparam int PTE_PR_LO   = 12;
    localparam int PTE_RSV_HI  = 11;
    localparam int PTE_RSV_LO  = 8;
    localparam int PTE_FN_HI   = 7;
    localparam int PTE_FN_LO   = 0;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int N      = 8,
    parameter int VPN_W  = 8,
    parameter int PFN_W  = 8,
    parameter int ASID_W = 8,
    parameter int PROT_W = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output logic [PFN_W-1:0]  hit_pfn,
    output logic [PROT_W-1:0] hit_prot,
    output logic [N-1:0]      valid_vec,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PROT_W-1:0] wr_prot
);
    logic [N-1:0]      hit_vec;
    logic [PFN_W-1:0]  pfn_a  [N];
    logic [PROT_W-1:0] prot_a [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic              v_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [PROT_W-1:0] prot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                vpn_q  <= '0;
                asid_q <= '0;
                pfn_q  <= '0;
                prot_q <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                v_q    <= 1'b1;
                vpn_q  <= wr_vpn;
                asid_q <= wr_asid;
                pfn_q  <= wr_pfn;
                prot_q <= wr_prot;
            end
        end

        assign valid_vec[g] = v_q;
        assign hit_vec[g]   = v_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
        assign pfn_a[g]     = pfn_q;
        assign prot_a[g]    = prot_q;
    end

    always_comb begin
        hit_pfn  = '0;
        hit_prot = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_pfn  = hit_pfn  | pfn_a[i];
                hit_prot = hit_prot | prot_a[i];
            end
        end
    end

    assign hit = |hit_vec;

    // R3: a (page, identifier) pair is never resident in two slots
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             advance,
    output logic [IDX_W-1:0] victim_idx
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance && !free_any) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    assign victim_idx = free_any ? free_idx : rr_q;

    // R9: the pointer only moves on a replacement with no free slot
    assert_rr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance || free_any) |=> $stable(rr_q));
endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int OFS_W     = 8,
    parameter int PFN_W     = 8,
    parameter int ASID_W    = 8,
    parameter int ENTRIES   = 8,
    parameter int PTE_BYTES = 2,
    localparam int VPN_W    = VA_W - OFS_W,
    localparam int PA_W     = PFN_W + OFS_W,
    localparam int PROT_W   = PTE_PR_HI - PTE_PR_LO + 1,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PTE_SH   = $clog2(PTE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              busy,
    output logic              done,
    output logic [PA_W-1:0]   paddr,
    output logic [PROT_W-1:0] prot,
    output logic              fault_seg,
    output logic              fault_page,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata
);
    xl_state_t st_q, st_d;

    logic [VA_W-1:0]   va_q;
    logic [ASID_W-1:0] asid_q;
    logic [VA_W-1:0]   base_q;
    logic [PFN_W-1:0]  fill_pfn_q;
    logic [PROT_W-1:0] fill_prot_q;

    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PROT_W-1:0] lk_prot;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]  victim;
    logic              refill;

    logic pte_v, pte_p, pte_rsv, pte_usable, walk_end;

    wire [VPN_W-1:0] vpn_w = va_q[VA_W-1:OFS_W];

    assign pte_rsv    = |mem_rdata[PTE_RSV_HI:PTE_RSV_LO];
    assign pte_v      = mem_rdata[PTE_V_BIT] && !pte_rsv;
    assign pte_p      = mem_rdata[PTE_P_BIT];
    assign pte_usable = pte_v && pte_p;
    assign walk_end   = (st_q == ST_WALK_WAIT) && mem_rvalid;
    assign refill     = (st_q == ST_REFILL);

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PROT_W(PROT_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(vpn_w), .lk_asid(asid_q),
        .hit(lk_hit), .hit_pfn(lk_pfn), .hit_prot(lk_prot),
        .valid_vec(valid_vec),
        .wr_en(refill), .wr_idx(victim), .wr_vpn(vpn_w), .wr_asid(asid_q),
        .wr_pfn(fill_pfn_q), .wr_prot(fill_prot_q)
    );

    tlb_victim_sel #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .advance(refill), .victim_idx(victim)
    );

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            va_q        <= '0;
            asid_q      <= '0;
            base_q      <= '0;
            fill_pfn_q  <= '0;
            fill_prot_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                asid_q <= cur_asid;
                base_q <= pt_base;
            end
            if (walk_end) begin
                fill_pfn_q  <= mem_rdata[PTE_FN_HI:PTE_FN_LO];
                fill_prot_q <= mem_rdata[PTE_PR_HI:PTE_PR_LO];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP:    st_d = lk_hit ? ST_IDLE : ST_WALK_REQ;
            ST_WALK_REQ:  st_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (mem_rvalid) st_d = pte_usable ? ST_REFILL : ST_IDLE;
            ST_REFILL:    st_d = ST_LOOKUP;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Registered result strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            fault_seg  <= 1'b0;
            fault_page <= 1'b0;
            paddr      <= '0;
            prot       <= '0;
        end else begin
            done       <= (st_q == ST_LOOKUP) && lk_hit;
            fault_seg  <= walk_end && !pte_v;
            fault_page <= walk_end && pte_v && !pte_p;
            if ((st_q == ST_LOOKUP) && lk_hit) begin
                paddr <= {lk_pfn, va_q[OFS_W-1:0]};
                prot  <= lk_prot;
            end
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign mem_req  = (st_q == ST_WALK_REQ);
    assign mem_addr = base_q + (VA_W'(vpn_w) << PTE_SH);

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault_seg, fault_page}));

    assert_busy_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault_seg || fault_page) |-> !busy);

    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_retry_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !flush) |=> ((st_q == ST_LOOKUP) && lk_hit));

    assert_strobe_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || fault_seg || fault_page));
endmodule

// File: tb/asid_tlb_xlate_bench.sv
`timescale 1ns/1ps
module asid_tlb_xlate_bench;
    localparam logic [15:0] PT_BASE = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [7:0]  cur_asid = 8'd0;
    logic [15:0] pt_base = PT_BASE;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        busy, done, fault_seg, fault_page, mem_req;
    logic [15:0] paddr, mem_addr;
    logic [1:0]  prot;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int walk_cnt = 0;
    int lat_seq = 0;
    logic [15:0] last_addr = '0;

    logic        r_done, r_seg, r_page, r_busy_ok, r_timeout;
    logic [15:0] r_pa;
    logic [1:0]  r_prot;
    int          r_lat, r_walks;

    always #2 clk = ~clk;

    asid_tlb_xlate u_asid_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cur_asid(cur_asid),
        .pt_base(pt_base), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .busy(busy), .done(done), .paddr(paddr), .prot(prot),
        .fault_seg(fault_seg), .fault_page(fault_page),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Page-table contents, computed from the page number (R5 layout)
    function automatic logic [15:0] pte_of(input logic [7:0] v);
        if (v % 13 == 0)      return 16'h0000;
        if (v == 8'hEE)       return 16'hC100 | {8'h00, v ^ 8'h5A};
        if (v % 7 == 3)       return 16'h8000 | {8'h00, v ^ 8'h5A};
        return 16'hC000 | {2'b00, 2'(v % 4), 12'h000} | {8'h00, v ^ 8'h5A};
    endfunction

    function automatic int kind_of(input logic [7:0] v);
        logic [15:0] p;
        p = pte_of(v);
        if (!p[15] || (p[11:8] != 0)) return 1;
        if (!p[14]) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: latency 1..3 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                int lat;
                walk_cnt++;
                last_addr = mem_addr;
                lat = 1 + (lat_seq % 3);
                lat_seq++;
                repeat (lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = pte_of(8'((last_addr - PT_BASE) >> 1));
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic xlate(input logic [15:0] va);
        @(negedge clk);
        walk_cnt  = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        r_busy_ok = 1'b1;
        r_timeout = 1'b0;
        while (!(done || fault_seg || fault_page)) begin
            if (!busy) r_busy_ok = 1'b0;
            if (r_lat > 300) begin
                r_timeout = 1'b1;
                break;
            end
            @(negedge clk);
            r_lat++;
        end
        r_done = done; r_seg = fault_seg; r_page = fault_page;
        r_pa = paddr; r_prot = prot; r_walks = walk_cnt;
        chk(!r_timeout, "R12", "request ended", r_timeout, 0);
        chk(r_busy_ok && !busy, "R11", "busy window", r_busy_ok, 1);
        chk((int'(r_done) + int'(r_seg) + int'(r_page)) == 1, "R12", "one outcome",
            {r_done, r_seg, r_page}, 0);
    endtask

    // Request expected to hit or miss; checks outcome from page table
    task automatic expect_xl(input logic [15:0] va, input int walks);
        logic [7:0] v;
        int k;
        v = va[15:8];
        k = kind_of(v);
        xlate(va);
        chk(r_walks == walks, (walks == 0) ? "R3" : "R4", "walk count", r_walks, walks);
        if (walks > 0)
            chk(last_addr == PT_BASE + 16'(v) * 2, "R4", "read address", last_addr,
                PT_BASE + 16'(v) * 2);
        if (k == 1) chk(r_seg, "R6", "seg fault", r_seg, 1);
        else if (k == 2) chk(r_page, "R7", "page fault", r_page, 1);
        else begin
            chk(r_done && r_pa == {v ^ 8'h5A, va[7:0]}, "R8", "paddr", r_pa,
                {v ^ 8'h5A, va[7:0]});
            chk(r_prot == 2'(v % 4), "R8", "prot", r_prot, v % 4);
            if (walks == 0) chk(r_lat == 2, "R2", "hit latency", r_lat, 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] good [9];
        int ng;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fault_seg && !fault_page && !mem_req, "R1", "reset idle",
            {busy, done, fault_seg, fault_page, mem_req}, 0);
        rst_n = 1'b1;
        cur_asid = 8'd211;
        ng = 0;
        for (int v = 1; v < 256 && ng < 9; v++) begin
            if (kind_of(8'(v)) == 0) begin
                good[ng] = 8'(v);
                ng++;
            end
        end
        // R9: fill slots 0..7 (free slots first)
        for (int i = 0; i < 8; i++) expect_xl({good[i], 8'(i * 17)}, 1);
        // R6/R7: faults do not disturb a full buffer
        expect_xl(16'h0012, 1);
        expect_xl(16'h0340, 1);
        expect_xl(16'h0341, 1);
        for (int i = 0; i < 8; i++) expect_xl({good[i], 8'(i + 3)}, 0);
        // R9: round robin starts at slot 0
        expect_xl({good[8], 8'h10}, 1);
        for (int i = 1; i < 9; i++) expect_xl({good[i], 8'h20}, 0);
        expect_xl({good[0], 8'h30}, 1);
        expect_xl({good[1], 8'h31}, 1);
        expect_xl({good[3], 8'h32}, 0);
        // R10: flush
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_xl({good[3], 8'h44}, 1);
        expect_xl({good[4], 8'h45}, 1);
        expect_xl({good[3], 8'h46}, 0);
        // R11: second request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {good[3], 8'h77};
        @(negedge clk);
        req_vaddr = {good[4], 8'h88};
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && paddr == {good[3] ^ 8'h5A, 8'h77}, "R11", "first request kept",
            paddr, {good[3] ^ 8'h5A, 8'h77});
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk(extra == 0, "R11", "ignored request", extra, 0);
        end
        // R3: identifier tagging
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        cur_asid = 8'd211; expect_xl({good[2], 8'h01}, 1);
        cur_asid = 8'd112; expect_xl({good[2], 8'h02}, 1);
        cur_asid = 8'd211; expect_xl({good[2], 8'h03}, 0);
        cur_asid = 8'd112; expect_xl({good[2], 8'h04}, 0);
        cur_asid = 8'd7;   expect_xl({good[2], 8'h05}, 1);
        // Sweep of all pages (R2, R5, R6, R7, R8)
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        cur_asid = 8'd211;
        for (int v = 0; v < 256; v++) begin
            expect_xl({8'(v), 8'(v * 3)}, 1);
            expect_xl({8'(v), 8'(v * 5 + 1)}, (kind_of(8'(v)) == 0) ? 0 : 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule